// File: doc/BRIEF.md
# External Interrupt Input Sensitivity Unit

This block turns groups of external interrupt pins into request lines for an interrupt priority controller. Each line owns a group of pins. A per-pin select mask chooses which pins of the group drive the line. When several pins are selected they are merged by a NAND into one line input. Each line input passes through a two-flop synchronizer and is then judged by a 2-bit sensitivity code. The code chooses a low-level request or an edge request. For an edge request the code also selects rising, falling or both edges.

An edge request is held in a pending flag. The flag clears by itself when the controller pulses that line's service-entry input. A level request has no flag and simply follows the synchronized input. The block also has one dedicated top-level input. It latches on a fixed edge, set by a parameter, and has its own service-entry clear. A combinational wake output is taken from the unsynchronized line inputs, so that a halted, clock-stopped system can be woken.

Top module: `exti_unit`

## Requirements
- R1: After reset every request output is low. The synchronizer stages reset to high (idle). With all pins high and no pin selected, wake_o is low.
- R2: A line's combined input is 1 when no pin of its group is selected. It equals the pin itself when exactly one pin is selected. It is the NAND of the selected pins when two or more are selected. Pin j of line i is bit i*PINS+j of pin_i and sel_i.
- R3: Sensitivity code 2'b00 (bits 2i+1:2i of mode_i) makes req_o[i] the inverse of the synchronized combined input. req_o[i] reflects a change of the combined input two clock edges after it, and no latch is involved.
- R4: Code 2'b01 latches rising edges, 2'b10 latches falling edges and 2'b11 latches both. The edge is seen by comparing the synchronized value with its previous-cycle copy. req_o[i] rises three clock edges after the combined input changes. An edge of the other polarity does not set the flag.
- R5: A pending flag stays set for as long as no service-entry pulse arrives, whatever the input does.
- R6: A one-cycle pulse on svc_i[i] clears a set pending flag at that clock edge.
- R7: If a new qualifying edge is detected in the same cycle as the service-entry pulse, the pending flag stays set.
- R8: wake_o is combinational from the unsynchronized combined inputs and needs no clock edge. It is high when any line input sits at its active level: low for codes 00 and 10, high for 01, and for 11 different from its synchronized copy. It is also high when any edge line or the top-level line is pending.
- R9: The top-level input latches only its parameter-selected edge (falling when TLI_RISING is 0) into tli_req_o three clock edges after the change. tli_svc_i clears it.
- R10: While a line is in code 00 its pending flag is cleared. A flag set before a switch to level mode does not come back when edge mode is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | LINES*PINS | External pins, grouped per line |
| sel_i | input | LINES*PINS | Pin select mask per line |
| mode_i | input | 2*LINES | Sensitivity code per line |
| svc_i | input | LINES | Service-entry pulse per line |
| tli_pin_i | input | 1 | Dedicated top-level interrupt pin |
| tli_svc_i | input | 1 | Service-entry pulse of the top-level line |
| req_o | output | LINES | Request per line |
| tli_req_o | output | 1 | Top-level request |
| wake_o | output | 1 | Combinational halt-wake signal |

## Verification
The hardest case to reach is a new edge that lands in exactly the cycle of the service-entry clear. The edge-detect window is one cycle wide and sits two edges after the pin change. The bench toggles a pin at a falling clock edge, counts two rising edges, and raises the service pulse for the third, so that both reach the pending flag together. NAND merging is covered by sweeping every select mask against every pin pattern in level mode.

// File: rtl/exti_pkg.sv
package exti_pkg;

    typedef enum logic [1:0] {
        SENS_LOW_LEVEL = 2'b00,
        SENS_RISE      = 2'b01,
        SENS_FALL      = 2'b10,
        SENS_BOTH      = 2'b11
    } sens_e;

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    localparam sync_t SYNC_IDLE = '{meta: 1'b1, sync: 1'b1, prev: 1'b1};

    function automatic logic edge_hit(sens_e mode, logic rise, logic fall);
        case (mode)
            SENS_RISE: edge_hit = rise;
            SENS_FALL: edge_hit = fall;
            SENS_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

    function automatic logic wake_level(sens_e mode, logic raw, logic synced);
        case (mode)
            SENS_RISE: wake_level = raw;
            SENS_BOTH: wake_level = raw ^ synced;
            default:   wake_level = ~raw;
        endcase
    endfunction

endpackage

// File: rtl/exti_combine.sv
module exti_combine #(
    parameter int PINS = 3
) (
    input  logic [PINS-1:0] pin_i,
    input  logic [PINS-1:0] sel_i,
    output logic            line_o
);
    localparam int CW = $clog2(PINS + 1);

    logic [CW-1:0] n_sel;

    always_comb begin
        n_sel = '0;
        for (int k = 0; k < PINS; k++) begin
            n_sel = n_sel + CW'(sel_i[k]);
        end
        if (n_sel == '0) begin
            line_o = 1'b1;
        end else if (n_sel == CW'(1)) begin
            line_o = |(pin_i & sel_i);
        end else begin
            line_o = ~&(pin_i | ~sel_i);
        end
    end
endmodule

// File: rtl/exti_line.sv
module exti_line
    import exti_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  raw_i,
    input  sens_e mode_i,
    input  logic  svc_i,
    output logic  req_o,
    output logic  pend_o,
    output logic  wake_o
);
    sync_t sq;
    logic  pend_q;
    logic  rise, fall, hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq <= SYNC_IDLE;
        end else begin
            sq.meta <= raw_i;
            sq.sync <= sq.meta;
            sq.prev <= sq.sync;
        end
    end

    assign rise = sq.sync & ~sq.prev;
    assign fall = ~sq.sync & sq.prev;
    assign hit  = edge_hit(mode_i, rise, fall);

    always_ff @(posedge clk) begin
        if (rst || mode_i == SENS_LOW_LEVEL) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~svc_i) | hit;
        end
    end

    assign req_o  = (mode_i == SENS_LOW_LEVEL) ? ~sq.sync : pend_q;
    assign pend_o = pend_q;
    assign wake_o = wake_level(mode_i, raw_i, sq.sync) | pend_q;

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        mode_i == SENS_LOW_LEVEL |=> !pend_q); // R10
    AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (pend_q && svc_i && !hit) |=> !pend_q); // R6
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
        (hit && mode_i != SENS_LOW_LEVEL) |=> pend_q); // R7
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !svc_i && mode_i != SENS_LOW_LEVEL) |=> pend_q); // R5
endmodule

// File: rtl/exti_unit.sv
module exti_unit
    import exti_pkg::*;
#(
    parameter int LINES      = 4,
    parameter int PINS       = 3,
    parameter bit TLI_RISING = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LINES*PINS-1:0] pin_i,
    input  logic [LINES*PINS-1:0] sel_i,
    input  logic [2*LINES-1:0]    mode_i,
    input  logic [LINES-1:0]      svc_i,
    input  logic                  tli_pin_i,
    input  logic                  tli_svc_i,
    output logic [LINES-1:0]      req_o,
    output logic                  tli_req_o,
    output logic                  wake_o
);
    localparam sens_e TLI_MODE = TLI_RISING ? SENS_RISE : SENS_FALL;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] line_wake;
    logic [LINES-1:0] line_pend;
    logic             tli_wake;
    logic             tli_pend;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        exti_combine #(.PINS(PINS)) u_comb (
            .pin_i  (pin_i[i*PINS +: PINS]),
            .sel_i  (sel_i[i*PINS +: PINS]),
            .line_o (raw[i])
        );
        exti_line u_line (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw[i]),
            .mode_i (sens_e'(mode_i[2*i +: 2])),
            .svc_i  (svc_i[i]),
            .req_o  (req_o[i]),
            .pend_o (line_pend[i]),
            .wake_o (line_wake[i])
        );
    end

    exti_line u_tli (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (tli_pin_i),
        .mode_i (TLI_MODE),
        .svc_i  (tli_svc_i),
        .req_o  (tli_req_o),
        .pend_o (tli_pend),
        .wake_o (tli_wake)
    );

    assign wake_o = (|line_wake) | tli_wake;

    AST_TLI_WAKES: assert property (@(posedge clk) disable iff (rst)
        tli_req_o |-> wake_o); // R8
    AST_PEND_WAKES: assert property (@(posedge clk) disable iff (rst)
        (|line_pend) |-> wake_o); // R8
    AST_TLI_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(tli_pend) |-> (tli_pin_i == TLI_RISING || $past(tli_pin_i) == TLI_RISING
                             || $past(tli_pin_i, 2) == TLI_RISING)); // R9
endmodule

// File: tb/tb_exti_unit.sv
module tb_exti_unit;
    localparam int L = 2;
    localparam int P = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [L*P-1:0] pin_i = '1;
    logic [L*P-1:0] sel_i = '0;
    logic [2*L-1:0] mode_i = '0;
    logic [L-1:0]   svc_i = '0;
    logic           tli_pin_i = 1'b1;
    logic           tli_svc_i = 1'b0;
    logic [L-1:0]   req_o;
    logic           tli_req_o;
    logic           wake_o;

    int checks = 0;
    int fails = 0;

    exti_unit #(.LINES(L), .PINS(P), .TLI_RISING(1'b0)) dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .sel_i(sel_i), .mode_i(mode_i),
        .svc_i(svc_i), .tli_pin_i(tli_pin_i), .tli_svc_i(tli_svc_i),
        .req_o(req_o), .tli_req_o(tli_req_o), .wake_o(wake_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_svc(input int line);
        svc_i[line] = 1'b1;
        edges(1);
        svc_i[line] = 1'b0;
    endtask

    function automatic logic comb_exp(input logic [P-1:0] p, input logic [P-1:0] s);
        int n = 0;
        logic nand_v = 1'b1;
        for (int k = 0; k < P; k++) if (s[k]) n++;
        if (n == 0) return 1'b1;
        nand_v = 1'b1;
        for (int k = 0; k < P; k++) if (s[k]) nand_v = nand_v & p[k];
        if (n == 1) return nand_v;
        return ~nand_v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        edges(3);
        rst = 1'b0;
        edges(1);
        // R1 reset state
        chk("R1", req_o[0], 1'b0);
        chk("R1", req_o[1], 1'b0);
        chk("R1", tli_req_o, 1'b0);
        chk("R1", wake_o, 1'b0);

        // R2/R3 combine sweep in level mode on both lines
        for (int ln = 0; ln < L; ln++) begin
            for (int s = 0; s < (1 << P); s++) begin
                for (int p = 0; p < (1 << P); p++) begin
                    sel_i = '0; pin_i = '1; mode_i = '0;
                    sel_i[ln*P +: P] = P'(s);
                    pin_i[ln*P +: P] = P'(p);
                    edges(2);
                    chk("R2_R3", req_o[ln], ~comb_exp(P'(p), P'(s)));
                end
            end
        end
        sel_i = '0; pin_i = '1; edges(3);

        // R4/R6 edge sweep on line 0, pin 0
        for (int m = 0; m < 4; m++) begin
            for (int from = 0; from < 2; from++) begin
                logic to;
                logic exp;
                to = ~from[0];
                sel_i = 4'b0001; mode_i = 4'(m);
                pin_i[0] = from[0];
                edges(4);
                pulse_svc(0);
                edges(1);
                pin_i[0] = to;
                edges(3);
                case (m)
                    0: exp = ~to;
                    1: exp = to;
                    2: exp = ~to;
                    default: exp = 1'b1;
                endcase
                chk("R3_R4", req_o[0], exp);
                pulse_svc(0);
                chk("R6", req_o[0], (m == 0) ? ~to : 1'b0);
            end
        end

        // R5 hold through input activity
        mode_i = 4'b0010; pin_i[0] = 1'b1; edges(4); pulse_svc(0);
        pin_i[0] = 1'b0; edges(3);
        chk("R4", req_o[0], 1'b1);
        pin_i[0] = 1'b1; edges(10);
        chk("R5", req_o[0], 1'b1);

        // R7 new edge in the service cycle
        mode_i = 4'b0011; edges(2); pulse_svc(0); edges(1);
        pin_i[0] = 1'b0; edges(3);
        chk("R4", req_o[0], 1'b1);
        pin_i[0] = 1'b1;
        edges(2);
        pulse_svc(0);
        chk("R7", req_o[0], 1'b1);
        pulse_svc(0);
        chk("R6", req_o[0], 1'b0);

        // R10 level mode drops pending
        mode_i = 4'b0001; pin_i[0] = 1'b0; edges(4); pulse_svc(0);
        pin_i[0] = 1'b1; edges(3);
        chk("R4", req_o[0], 1'b1);
        mode_i = 4'b0000; edges(1);
        chk("R10", req_o[0], 1'b0);
        mode_i = 4'b0001; edges(1);
        chk("R10", req_o[0], 1'b0);

        // R8 wake without clock edge
        mode_i = 4'b0000; pin_i = '1; edges(3);
        chk("R8", wake_o, 1'b0);
        @(posedge clk); #2;
        pin_i[0] = 1'b0; #1;
        chk("R8", wake_o, 1'b1);
        pin_i[0] = 1'b1; #1;
        chk("R8", wake_o, 1'b0);
        mode_i = 4'b0001; #1;
        chk("R8", wake_o, 1'b1);
        mode_i = 4'b0000; edges(3);

        // R9 top-level input, falling edge only
        tli_pin_i = 1'b0; edges(3);
        chk("R9", tli_req_o, 1'b1);
        chk("R8", wake_o, 1'b1);
        tli_svc_i = 1'b1; edges(1); tli_svc_i = 1'b0;
        chk("R9", tli_req_o, 1'b0);
        tli_pin_i = 1'b1; edges(4);
        chk("R9", tli_req_o, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule